// File: doc/BRIEF.md
# Banked RGB Palette Memory Controller

The block stores a color palette as three separate 8-bit planes, one each for red, green and blue, and gives two clients access to them. A byte-wide CPU port reads and writes single color bytes. A video port supplies one pen index per pixel clock and receives the full 24-bit color of that pen one clock later. The CPU address map interleaves the planes. Two address bits in the middle of the address pick red, green, blue or a small register window. The two top address bits become the high bits of the pen index, so the pens fall into four banks.

Accesses that land in the register window never touch the planes. They are forwarded to a separate control-register block through a pass-through port that carries the low four address bits, the write data and the strobes. The register window appears once in every bank, and all four copies map to the same registers. Data returned by that block is folded into the CPU read path.

The offset width `OFS_W` sets the number of pens per bank (2^OFS_W). The full-size palette uses `OFS_W = 11`: a 15-bit CPU address, 13-bit pens, 8192 entries per plane, and target-select bits at 12:11. The default of 8 gives a smaller build with the same map shape. In the requirements below, S denotes the select field `cpu_addr[OFS_W+1:OFS_W]`.

Top module: `pal_bank_ctrl`

## Requirements
- R1: The select field S picks the target of a CPU access: 0 is red, 1 is green, 2 is blue, and 3 is the register window.
- R2: The pen index of a CPU access is `{cpu_addr[ADDR_W-1:ADDR_W-2], cpu_addr[OFS_W-1:0]}`, which gives four banks of 2^OFS_W pens. The select field is not part of the pen index.
- R3: A CPU write with S in 0..2 stores `cpu_wdata` at the computed pen of the selected plane only. The same pen in the other two planes keeps its value.
- R4: A CPU read with S in 0..2 loads `cpu_rdata` at the clock edge that samples `cpu_rd`. The loaded value is the byte at the computed pen of the selected plane. `cpu_rdata` holds its value in every cycle that follows without a read, including cycles with writes.
- R5: While `cpu_rd` or `cpu_wr` is high with S = 3, the following outputs are driven combinationally: `reg_sel` is 1, `reg_addr` equals `cpu_addr[3:0]`, `reg_wdata` equals `cpu_wdata`, and `reg_rd`/`reg_wr` follow the strobes. This holds in every bank and for any value of `cpu_addr[OFS_W-1:4]`. No plane entry changes.
- R6: A CPU read with S = 3 loads `cpu_rdata` at the sampling edge with the value of `reg_rdata` present in that cycle.
- R7: `reg_sel`, `reg_rd` and `reg_wr` are 0 whenever there is no strobe or S is not 3.
- R8: `vid_rgb` equals `{red, green, blue}` (red in bits 23:16, blue in 7:0) of the pen that was on `vid_pen` one clock earlier.
- R9: If `vid_pen` carries the written pen in the cycle right after a plane write, the next `vid_rgb` shows the written byte.
- R10: While `rst_n` is low, `cpu_rdata` and `vid_rgb` read 0. Plane contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| cpu_addr | input | OFS_W+4 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe, one cycle per read |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | COL_W | CPU write byte |
| cpu_rdata | output | COL_W | Registered CPU read byte |
| reg_sel | output | 1 | Register window is being accessed |
| reg_rd | output | 1 | Read strobe to the register block |
| reg_wr | output | 1 | Write strobe to the register block |
| reg_addr | output | 4 | Register byte offset |
| reg_wdata | output | COL_W | Write byte to the register block |
| reg_rdata | input | COL_W | Read byte from the register block |
| vid_pen | input | OFS_W+2 | Pen index for the video lookup |
| vid_rgb | output | 3*COL_W | Registered {red, green, blue} of the looked-up pen |

## Verification
Every pen in every plane and bank is filled with a value that depends on plane and bank, then read back on both ports. A decoder that drops the folded bank bits, swaps two planes or takes the select bits into the pen index therefore returns the wrong byte. The register window is accessed through all four mirrors with junk in the middle address bits. A decoder that fails to fold the mirrors forwards the wrong offset, and one that lets window writes reach a plane corrupts pens that the bench then inspects. The bench also checks that the read byte survives later writes, and it probes a video lookup of a pen in the cycle after that pen is written. An extra pipeline stage or a wrong plane enable shows up there as stale color.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Target of a CPU access, in select-field encoding
    typedef enum logic [1:0] {
        PLN_RED = 2'd0,
        PLN_GRN = 2'd1,
        PLN_BLU = 2'd2,
        PLN_WIN = 2'd3
    } pal_tgt_e;

    localparam int NUM_PLANES = 3;
    localparam int WIN_OFS_W  = 4;

endpackage

// File: rtl/pal_addr_dec.sv
module pal_addr_dec
    import pal_pkg::*;
#(
    parameter  int OFS_W  = 8,
    localparam int ADDR_W = OFS_W + 4,
    localparam int PEN_W  = OFS_W + 2
) (
    input  logic [ADDR_W-1:0]     addr,
    output pal_tgt_e              tgt,
    output logic [PEN_W-1:0]      pen,
    output logic [WIN_OFS_W-1:0]  win_ofs,
    output logic [NUM_PLANES-1:0] plane_hit
);

    // Select field sits directly above the in-bank offset
    assign tgt     = pal_tgt_e'(addr[OFS_W+1:OFS_W]);
    // Bank bits fold down over the select field
    assign pen     = {addr[ADDR_W-1:ADDR_W-2], addr[OFS_W-1:0]};
    assign win_ofs = addr[WIN_OFS_W-1:0];

    for (genvar g = 0; g < NUM_PLANES; g++) begin : g_hit
        assign plane_hit[g] = (addr[OFS_W+1:OFS_W] == 2'(g));
    end

endmodule

// File: rtl/pal_plane_ram.sv
module pal_plane_ram #(
    parameter  int PEN_W = 10,
    parameter  int COL_W = 8,
    localparam int DEPTH = 1 << PEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic             cpu_re,
    input  logic [PEN_W-1:0] cpu_pen,
    input  logic [COL_W-1:0] cpu_wdata,
    output logic [COL_W-1:0] cpu_q,
    input  logic [PEN_W-1:0] vid_pen,
    output logic [COL_W-1:0] vid_q
);

    logic [COL_W-1:0] mem [DEPTH];

    typedef struct packed {
        logic [COL_W-1:0] cpu;
        logic [COL_W-1:0] vid;
    } port_regs_t;

    port_regs_t p_d, p_q;

    // Reads see the array before a write at the same edge
    always_comb begin
        p_d = p_q;
        if (cpu_re) begin
            p_d.cpu = mem[cpu_pen];
        end
        p_d.vid = mem[vid_pen];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk) begin
        if (cpu_we) begin
            mem[cpu_pen] <= cpu_wdata;
        end
    end

    assign cpu_q = p_q.cpu;
    assign vid_q = p_q.vid;

endmodule

// File: rtl/pal_win_port.sv
module pal_win_port
    import pal_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                 win_hit,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    input  logic [WIN_OFS_W-1:0] win_ofs,
    input  logic [COL_W-1:0]     cpu_wdata,
    output logic                 reg_sel,
    output logic                 reg_rd,
    output logic                 reg_wr,
    output logic [WIN_OFS_W-1:0] reg_addr,
    output logic [COL_W-1:0]     reg_wdata
);

    always_comb begin
        reg_rd    = win_hit & cpu_rd;
        reg_wr    = win_hit & cpu_wr;
        reg_sel   = reg_rd | reg_wr;
        reg_addr  = win_ofs;
        reg_wdata = cpu_wdata;
    end

endmodule

// File: rtl/pal_bank_ctrl.sv
module pal_bank_ctrl
    import pal_pkg::*;
#(
    parameter  int OFS_W  = 8,
    parameter  int COL_W  = 8,
    localparam int ADDR_W = OFS_W + 4,
    localparam int PEN_W  = OFS_W + 2,
    localparam int RGB_W  = NUM_PLANES * COL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    input  logic [COL_W-1:0]     cpu_wdata,
    output logic [COL_W-1:0]     cpu_rdata,
    output logic                 reg_sel,
    output logic                 reg_rd,
    output logic                 reg_wr,
    output logic [WIN_OFS_W-1:0] reg_addr,
    output logic [COL_W-1:0]     reg_wdata,
    input  logic [COL_W-1:0]     reg_rdata,
    input  logic [PEN_W-1:0]     vid_pen,
    output logic [RGB_W-1:0]     vid_rgb
);

    pal_tgt_e              dec_tgt;
    logic [PEN_W-1:0]      dec_pen;
    logic [WIN_OFS_W-1:0]  dec_ofs;
    logic [NUM_PLANES-1:0] dec_hit;

    pal_addr_dec #(.OFS_W(OFS_W)) i_dec (
        .addr      (cpu_addr),
        .tgt       (dec_tgt),
        .pen       (dec_pen),
        .win_ofs   (dec_ofs),
        .plane_hit (dec_hit)
    );

    pal_win_port #(.COL_W(COL_W)) i_win (
        .win_hit   (dec_tgt == PLN_WIN),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .win_ofs   (dec_ofs),
        .cpu_wdata (cpu_wdata),
        .reg_sel   (reg_sel),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    logic [NUM_PLANES-1:0][COL_W-1:0] plane_cpu_q;
    logic [NUM_PLANES-1:0][COL_W-1:0] plane_vid_q;

    for (genvar g = 0; g < NUM_PLANES; g++) begin : g_plane
        pal_plane_ram #(.PEN_W(PEN_W), .COL_W(COL_W)) i_ram (
            .clk       (clk),
            .rst_n     (rst_n),
            .cpu_we    (cpu_wr & dec_hit[g]),
            .cpu_re    (cpu_rd & dec_hit[g]),
            .cpu_pen   (dec_pen),
            .cpu_wdata (cpu_wdata),
            .cpu_q     (plane_cpu_q[g]),
            .vid_pen   (vid_pen),
            .vid_q     (plane_vid_q[g])
        );
        // Red lands in the top byte
        assign vid_rgb[RGB_W-1-g*COL_W -: COL_W] = plane_vid_q[g];
    end

    // Which source the last CPU read came from, plus the captured register byte
    typedef struct packed {
        pal_tgt_e         rsel;
        logic [COL_W-1:0] regbyte;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_rd) begin
            st_d.rsel = dec_tgt;
            if (dec_tgt == PLN_WIN) begin
                st_d.regbyte = reg_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rsel: PLN_WIN, regbyte: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.rsel)
            PLN_RED: cpu_rdata = plane_cpu_q[0];
            PLN_GRN: cpu_rdata = plane_cpu_q[1];
            PLN_BLU: cpu_rdata = plane_cpu_q[2];
            default: cpu_rdata = st_q.regbyte;
        endcase
    end

endmodule

// File: rtl/pal_bank_ctrl_chk.sv
module pal_bank_ctrl_chk #(
    parameter  int OFS_W  = 8,
    parameter  int COL_W  = 8,
    localparam int ADDR_W = OFS_W + 4,
    localparam int PEN_W  = OFS_W + 2,
    localparam int RGB_W  = 3 * COL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [COL_W-1:0]  cpu_wdata,
    input logic [COL_W-1:0]  cpu_rdata,
    input logic              reg_sel,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [3:0]        reg_addr,
    input logic [COL_W-1:0]  reg_wdata,
    input logic [COL_W-1:0]  reg_rdata,
    input logic [PEN_W-1:0]  vid_pen,
    input logic [RGB_W-1:0]  vid_rgb
);

    logic [1:0]       c_tgt;
    logic             c_win;
    logic             c_acc;
    logic [PEN_W-1:0] c_pen;

    assign c_tgt = cpu_addr[OFS_W+1:OFS_W];
    assign c_win = (c_tgt == 2'd3);
    assign c_acc = cpu_rd | cpu_wr;
    assign c_pen = {cpu_addr[ADDR_W-1:ADDR_W-2], cpu_addr[OFS_W-1:0]};

    function automatic logic [COL_W-1:0] pick(input logic [RGB_W-1:0] rgb, input logic [1:0] t);
        case (t)
            2'd0:    pick = rgb[3*COL_W-1:2*COL_W];
            2'd1:    pick = rgb[2*COL_W-1:COL_W];
            default: pick = rgb[COL_W-1:0];
        endcase
    endfunction

    AST_WIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_acc && c_win) |-> (reg_sel && reg_addr == cpu_addr[3:0] && reg_wr == cpu_wr
                              && reg_rd == cpu_rd && reg_wdata == cpu_wdata)); // R5

    AST_WIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_acc && c_win) |-> (!reg_sel && !reg_wr && !reg_rd)); // R7

    AST_REG_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && c_win) |=> (cpu_rdata == $past(reg_rdata))); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata)); // R4

    AST_VID_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_wr) && $past(c_tgt) != 2'd3 && vid_pen == $past(c_pen)
         && !(cpu_wr && cpu_addr == $past(cpu_addr)))
        |=> (pick(vid_rgb, $past(c_tgt, 2)) == $past(cpu_wdata, 2))); // R9

    AST_RST_ZERO: assert property (@(posedge clk)
        !rst_n |=> (cpu_rdata == '0 && vid_rgb == '0)); // R10

endmodule

bind pal_bank_ctrl pal_bank_ctrl_chk #(.OFS_W(OFS_W), .COL_W(COL_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .reg_sel   (reg_sel),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .vid_pen   (vid_pen),
    .vid_rgb   (vid_rgb)
);

// File: tb/test_pal_bank_ctrl.sv
`timescale 1ns/1ps
module test_pal_bank_ctrl;

    localparam int OFS_W  = 8;
    localparam int ADDR_W = OFS_W + 4;
    localparam int PEN_W  = OFS_W + 2;
    localparam int NPEN   = 1 << PEN_W;
    localparam int BANKSZ = 1 << OFS_W;

    logic              clk;
    logic              rst_n;
    logic [ADDR_W-1:0] cpu_addr;
    logic              cpu_rd;
    logic              cpu_wr;
    logic [7:0]        cpu_wdata;
    logic [7:0]        cpu_rdata;
    logic              reg_sel;
    logic              reg_rd;
    logic              reg_wr;
    logic [3:0]        reg_addr;
    logic [7:0]        reg_wdata;
    logic [7:0]        reg_rdata;
    logic [PEN_W-1:0]  vid_pen;
    logic [23:0]       vid_rgb;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    pal_bank_ctrl #(.OFS_W(OFS_W)) i_pal_bank_ctrl (
        .clk, .rst_n, .cpu_addr, .cpu_rd, .cpu_wr, .cpu_wdata, .cpu_rdata,
        .reg_sel, .reg_rd, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .vid_pen, .vid_rgb
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Stand-in register block on the window port
    logic [7:0] regfile [16];
    assign reg_rdata = regfile[reg_addr];
    always @(posedge clk) if (reg_wr) regfile[reg_addr] <= reg_wdata;

    function automatic logic [7:0] exp_byte(int pl, int pen);
        return 8'((pen % BANKSZ) + (pen / BANKSZ) * 64 + pl * 23 + 5);
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(int sel, int pen);
        return ADDR_W'(((pen / BANKSZ) << (OFS_W + 2)) | (sel << OFS_W) | (pen % BANKSZ));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        if (a[OFS_W+1:OFS_W] == 2'd3) begin
            check("R5 sel",   {31'd0, reg_sel}, 32'd1);
            check("R5 wr",    {31'd0, reg_wr},  32'd1);
            check("R5 addr",  {28'd0, reg_addr}, {28'd0, a[3:0]});
            check("R5 wdata", {24'd0, reg_wdata}, {24'd0, d});
        end else begin
            check("R7 quiet", {29'd0, reg_sel, reg_wr, reg_rd}, 32'd0);
        end
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        if (a[OFS_W+1:OFS_W] == 2'd3) begin
            check("R5 rd", {30'd0, reg_sel, reg_rd}, 32'd3);
        end
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic vid_look(input int pen, output logic [23:0] rgb);
        @(negedge clk);
        vid_pen = PEN_W'(pen);
        @(negedge clk);
        rgb = vid_rgb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        logic [23:0] rgb;
        for (int i = 0; i < 16; i++) regfile[i] = 8'h00;
        rst_n = 1'b0; cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        cpu_wdata = '0; vid_pen = PEN_W'(5);
        repeat (4) @(negedge clk);
        // R10: outputs idle under reset
        check("R10 rdata", {24'd0, cpu_rdata}, 32'd0);
        check("R10 rgb",   {8'd0, vid_rgb},    32'd0);
        check("R10 sel",   {31'd0, reg_sel},   32'd0);
        rst_n = 1'b1;

        // Fill every pen of every plane (R1, R2, R3)
        for (int pl = 0; pl < 3; pl++)
            for (int pen = 0; pen < NPEN; pen++)
                cpu_write(mk_addr(pl, pen), exp_byte(pl, pen));

        // CPU readback across planes and banks
        for (int pl = 0; pl < 3; pl++)
            for (int pen = 0; pen < NPEN; pen++) begin
                cpu_read(mk_addr(pl, pen), rd);
                if (pen >= BANKSZ) check("R2 bank fold", {24'd0, rd}, {24'd0, exp_byte(pl, pen)});
                else               check("R1 plane sel", {24'd0, rd}, {24'd0, exp_byte(pl, pen)});
            end

        // R4: read byte survives idle cycles and writes
        cpu_read(mk_addr(1, 700), rd);
        check("R4 read", {24'd0, rd}, {24'd0, exp_byte(1, 700)});
        cpu_write(mk_addr(0, 3), exp_byte(0, 3));
        repeat (3) @(negedge clk);
        check("R4 hold", {24'd0, cpu_rdata}, {24'd0, exp_byte(1, 700)});

        // R8: video lookup of every pen
        for (int pen = 0; pen < NPEN; pen++) begin
            vid_look(pen, rgb);
            check("R8 video", {8'd0, rgb},
                  {8'd0, exp_byte(0, pen), exp_byte(1, pen), exp_byte(2, pen)});
        end

        // R5/R6: register window in all four banks, read back through another mirror
        for (int b = 0; b < 4; b++) begin
            int mid = (b * 3 + 1) % 16;
            int ofs = (b * 5 + 3) % 16;
            logic [ADDR_W-1:0] wa = ADDR_W'((b << (OFS_W + 2)) | (3 << OFS_W) | (mid << 4) | ofs);
            int ob = (b + 1) % 4;
            logic [ADDR_W-1:0] ra = ADDR_W'((ob << (OFS_W + 2)) | (3 << OFS_W) | (((mid + 7) % 16) << 4) | ofs);
            cpu_write(wa, 8'(8'hA0 + b));
            cpu_read(ra, rd);
            check("R6 reg read", {24'd0, rd}, {24'd0, 8'(8'hA0 + b)});
            // Planes at the matching pen stay intact
            vid_look(b * BANKSZ + mid * 16 + ofs, rgb);
            check("R5 no plane write", {8'd0, rgb},
                  {8'd0, exp_byte(0, b * BANKSZ + mid * 16 + ofs),
                   exp_byte(1, b * BANKSZ + mid * 16 + ofs),
                   exp_byte(2, b * BANKSZ + mid * 16 + ofs)});
        end

        // R9/R3: write then look up the same pen in the next cycle
        cpu_write(mk_addr(0, 677), 8'h3C);
        vid_pen = PEN_W'(677);
        @(negedge clk);
        check("R9 red fresh", {24'd0, vid_rgb[23:16]}, 32'h3C);
        check("R3 green kept", {24'd0, vid_rgb[15:8]}, {24'd0, exp_byte(1, 677)});
        check("R3 blue kept",  {24'd0, vid_rgb[7:0]},  {24'd0, exp_byte(2, 677)});

        cpu_write(mk_addr(2, 1000), 8'hC5);
        vid_pen = PEN_W'(1000);
        @(negedge clk);
        check("R9 blue fresh", {24'd0, vid_rgb[7:0]},  32'hC5);
        check("R3 red kept",   {24'd0, vid_rgb[23:16]}, {24'd0, exp_byte(0, 1000)});

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule